// File: doc/BRIEF.md
# HDLC Transmit Queue with Per-Byte Tags

This block takes bytes from a processor and sends them as a bit-oriented HDLC stream. Software writes bytes through a small register port into a 16-entry queue. Each queue entry holds the byte and two sideband marks: end-of-frame and abort. Before writing a byte, software can arm either mark in a control register. The mark then travels with exactly that byte, and the control register returns to zero as soon as the byte is written.

A serializer takes entries from the head of the queue, one bit per `bit_en` cycle. Between frames it sends flags. It wraps each frame in flags and stuffs a zero after every run of five ones in the payload and frame check bits. It appends a 16-bit frame check sequence after the end-of-frame byte. A byte marked abort is not sent; the serializer sends eight ones in its place. If the queue runs dry in the middle of a frame, the serializer raises `underrun` and aborts the frame.

Writes have no handshake. `fifo_full` is the only back-pressure, and software must check it before writing, because a byte written while the queue is full is lost. Inside the block, the queue feeds the serializer over a valid/ready link. The serializer asserts ready only in the cycle where it finishes a flag or a payload byte, and then only on a `bit_en` cycle.

Top module: `hdlc_txq`

## Requirements
- R1: A write to address 1 loads the tag bits from `wr_data` (bit 0 is end-of-frame, bit 1 is abort), and `ctrl_rdata[1:0]` shows them. Any write to address 0 clears both tag bits from the next cycle on, even when the byte is dropped.
- R2: Tags armed before a data write apply to that single byte only. Later bytes are stored untagged.
- R3: A byte tagged abort is never sent. When it reaches the head of the queue, eight ones without stuffing are sent in its place, and flags follow.
- R4: After the end-of-frame byte, a 16-bit frame check sequence is sent, followed by a closing flag 0x7E. The sequence is a CRC with initial value 0xFFFF and reflected polynomial 0x8408, run over the data bits LSB first; the block sends its ones complement, LSB first.
- R5: After five consecutive ones from payload or frame check bits, one zero is inserted. Flags and the abort pattern are never stuffed.
- R6: While the queue is empty between frames, flags 0x7E are sent back to back, and at least one flag comes before every frame. From reset until the first bit slot, `tx_bit` is 1.
- R7: The queue holds 16 entries. A data write while it is full is dropped, and the stored entries are unchanged.
- R8: If the queue is empty when the next payload byte of an unfinished frame is due, `underrun` pulses for one cycle and the frame is aborted with eight ones.
- R9: `fifo_empty` is 1 exactly when the queue holds no entry, and `fifo_full` is 1 exactly when it holds 16. After reset the queue is empty.
- R10: Each byte is sent LSB first. `tx_bit` changes only on a clock edge where `bit_en` is 1, and each such edge sends one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-slot strobe: one line bit per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: data byte into the queue, 1: tag control |
| wr_data | input | 8 | Write data |
| ctrl_rdata | output | 8 | Tag control readback: {6'b0, abort, end-of-frame} |
| fifo_full | output | 1 | Queue holds 16 entries |
| fifo_empty | output | 1 | Queue holds no entry |
| underrun | output | 1 | One-cycle pulse when a frame runs out of data |
| tx_bit | output | 1 | Serial HDLC line output |

## Verification
The bench decodes the line with its own HDLC receiver. The receiver finds flags, removes stuffed zeros, detects aborts and checks the frame check residue. The bench then compares the decoded frames with the bytes it wrote.

The frame patterns are chosen to separate faults:
- A one-byte frame exercises the shortest path through the check sequence.
- Frames of all-ones bytes and of bytes equal to the flag pattern separate correct stuffing from missing or extra stuffing.
- Zero bytes and mixed byte ramps expose bit-order and CRC errors.

A frame with an abort-tagged byte in the middle shows three things: the tagged byte is replaced, the tag does not leak onto the following bytes, and the bytes after the abort form a clean new frame. A lone byte without the end-of-frame mark triggers an underrun. Filling the queue while the line is held still shows the full flag and the dropped seventeenth byte.

// File: rtl/hdlc_txq_pkg.sv
package hdlc_txq_pkg;
  localparam int BYTE_W = 8;
  localparam int FCS_W  = 16;
  localparam logic [BYTE_W-1:0] FLAG_PAT  = 8'h7E;
  localparam logic [BYTE_W-1:0] ABORT_PAT = 8'hFF;
  localparam logic [FCS_W-1:0]  CRC_POLY_REV = 16'h8408;
  localparam logic [FCS_W-1:0]  CRC_INIT     = 16'hFFFF;
  localparam int STUFF_RUN = 5;

  typedef struct packed {
    logic              abort;
    logic              eof;
    logic [BYTE_W-1:0] data;
  } txq_entry_t;

  typedef enum logic [1:0] {
    M_FLAG  = 2'd0,
    M_DATA  = 2'd1,
    M_FCS   = 2'd2,
    M_ABORT = 2'd3
  } ser_mode_t;
endpackage

// File: rtl/hdlc_txq_regs.sv
module hdlc_txq_regs
  import hdlc_txq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ctrl_rdata,
  output logic              push_valid,
  output txq_entry_t        push_entry
);
  logic tag_eof_q, tag_abort_q;
  logic data_wr, ctrl_wr;
  logic unused_ctrl_bits;

  assign data_wr = wr_en && (wr_addr == 1'b0);
  assign ctrl_wr = wr_en && (wr_addr == 1'b1);
  assign unused_ctrl_bits = ^wr_data[BYTE_W-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_eof_q   <= 1'b0;
      tag_abort_q <= 1'b0;
    end else if (ctrl_wr) begin
      tag_eof_q   <= wr_data[0];
      tag_abort_q <= wr_data[1];
    end else if (data_wr) begin
      tag_eof_q   <= 1'b0;
      tag_abort_q <= 1'b0;
    end
  end

  assign push_valid       = data_wr;
  assign push_entry.data  = wr_data;
  assign push_entry.eof   = tag_eof_q;
  assign push_entry.abort = tag_abort_q;
  assign ctrl_rdata       = {{(BYTE_W-2){1'b0}}, tag_abort_q, tag_eof_q};

  assert_tags_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (ctrl_rdata == '0));
endmodule

// File: rtl/hdlc_txq_fifo.sv
module hdlc_txq_fifo
  import hdlc_txq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  txq_entry_t in_entry,
  output logic       in_ready,
  output logic       out_valid,
  output txq_entry_t out_entry,
  input  logic       out_ready,
  output logic       full,
  output logic       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);

  txq_entry_t mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic push, pop;

  assign full      = (count == FULL_CNT);
  assign empty     = (count == '0);
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_entry = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !out_ready) |=> (full && $stable(wr_ptr)));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: rtl/hdlc_txq_ser.sv
module hdlc_txq_ser
  import hdlc_txq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       head_valid,
  input  txq_entry_t head_entry,
  output logic       head_ready,
  output logic       underrun,
  output logic       tx_bit
);
  localparam int CW = $clog2(FCS_W + 1);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam logic [CW-1:0] BYTE_CNT = CW'(BYTE_W);
  localparam logic [CW-1:0] FCS_CNT  = CW'(FCS_W);
  localparam logic [OW-1:0] RUN_MAX  = OW'(STUFF_RUN);

  ser_mode_t        mode;
  logic [FCS_W-1:0] shreg;
  logic [CW-1:0]    bits_left;
  logic [OW-1:0]    ones;
  logic [FCS_W-1:0] crc, crc_nxt;
  logic             cur_eof;
  logic             stuff, last, cur_bit, need_byte, stuffable;

  assign stuff     = (ones == RUN_MAX);
  assign last      = (bits_left == CW'(1));
  assign cur_bit   = shreg[0];
  assign stuffable = (mode == M_DATA) || (mode == M_FCS);
  assign need_byte = (mode == M_FLAG) || ((mode == M_DATA) && !cur_eof);

  always_comb begin
    crc_nxt = crc >> 1;
    if (crc[0] ^ cur_bit) crc_nxt = crc_nxt ^ CRC_POLY_REV;
  end

  assign head_ready = bit_en && !stuff && last && need_byte;
  assign underrun   = bit_en && !stuff && last && (mode == M_DATA) && !cur_eof && !head_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= M_FLAG;
      shreg     <= {{(FCS_W-BYTE_W){1'b0}}, FLAG_PAT};
      bits_left <= BYTE_CNT;
      ones      <= '0;
      crc       <= CRC_INIT;
      cur_eof   <= 1'b0;
      tx_bit    <= 1'b1;
    end else if (bit_en) begin
      if (stuff) begin
        tx_bit <= 1'b0;
        ones   <= '0;
      end else begin
        tx_bit    <= cur_bit;
        shreg     <= shreg >> 1;
        bits_left <= bits_left - CW'(1);
        ones      <= (stuffable && cur_bit) ? ones + OW'(1) : '0;
        if (mode == M_DATA) crc <= crc_nxt;
        if (last) begin
          if (need_byte && head_valid) begin
            bits_left <= BYTE_CNT;
            if (head_entry.abort) begin
              mode  <= M_ABORT;
              shreg <= {{(FCS_W-BYTE_W){1'b0}}, ABORT_PAT};
            end else begin
              mode    <= M_DATA;
              shreg   <= {{(FCS_W-BYTE_W){1'b0}}, head_entry.data};
              cur_eof <= head_entry.eof;
              if (mode == M_FLAG) crc <= CRC_INIT;
            end
          end else if (mode == M_DATA && cur_eof) begin
            mode      <= M_FCS;
            shreg     <= ~crc_nxt;
            bits_left <= FCS_CNT;
          end else if (mode == M_DATA) begin
            mode      <= M_ABORT;
            shreg     <= {{(FCS_W-BYTE_W){1'b0}}, ABORT_PAT};
            bits_left <= BYTE_CNT;
          end else begin
            mode      <= M_FLAG;
            shreg     <= {{(FCS_W-BYTE_W){1'b0}}, FLAG_PAT};
            bits_left <= BYTE_CNT;
          end
        end
      end
    end
  end

  assert_stuff_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff) |=> !tx_bit);

  assert_abort_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && mode == M_ABORT && !stuff) |=> tx_bit);

  assert_underrun_aborts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> (mode == M_ABORT));

  assert_line_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));
endmodule

// File: rtl/hdlc_txq.sv
module hdlc_txq
  import hdlc_txq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ctrl_rdata,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              underrun,
  output logic              tx_bit
);
  logic       push_valid, push_ready;
  txq_entry_t push_entry, head_entry;
  logic       head_valid, head_ready;

  hdlc_txq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_rdata(ctrl_rdata), .push_valid(push_valid), .push_entry(push_entry)
  );

  hdlc_txq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(push_valid), .in_entry(push_entry), .in_ready(push_ready),
    .out_valid(head_valid), .out_entry(head_entry), .out_ready(head_ready),
    .full(fifo_full), .empty(fifo_empty)
  );

  hdlc_txq_ser u_ser (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .head_valid(head_valid), .head_entry(head_entry), .head_ready(head_ready),
    .underrun(underrun), .tx_bit(tx_bit)
  );

  assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !push_ready);
endmodule

// File: tb/hdlc_txq_tb.sv
module hdlc_txq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {length, first byte, step}
  localparam logic [23:0] VECS [NVEC] = '{
    {8'd1,  8'h55, 8'h00},
    {8'd4,  8'hFF, 8'h00},
    {8'd6,  8'h7E, 8'h01},
    {8'd8,  8'h00, 8'h00},
    {8'd12, 8'h1F, 8'h3B}
  };

  logic clk = 0, rst_n = 0, bit_en = 0, wr_en = 0, wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] ctrl_rdata;
  logic fifo_full, fifo_empty, underrun, tx_bit;

  int n_cmp = 0, n_bad = 0;
  logic ser_run = 1;
  int div = 0;
  logic samp = 0;
  logic ur_seen = 0;

  // receiver state
  logic rx_bits [2048];
  int   rx_nbits = 0, rx_ones = 0;
  logic rx_in_frame = 0;
  int   rx_frames = 0, rx_aborts = 0, rx_flags = 0, rx_len = 0;
  logic rx_crc_ok = 0;
  logic [7:0] rx_bytes [64];

  hdlc_txq u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_rdata(ctrl_rdata), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .underrun(underrun), .tx_bit(tx_bit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    div = (div == 2) ? 0 : div + 1;
    bit_en <= ser_run && rst_n && (div == 0);
  end

  always @(posedge clk) begin
    samp <= bit_en;
    if (underrun) ur_seen <= 1'b1;
  end

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic [15:0] n;
    n = c >> 1;
    if (c[0] ^ b) n = n ^ 16'h8408;
    return n;
  endfunction

  task automatic close_frame();
    int nb;
    logic [15:0] c;
    nb = rx_nbits - 7;
    if (rx_in_frame && nb > 0) begin
      c = 16'hFFFF;
      for (int i = 0; i < nb; i++) c = crc_step(c, rx_bits[i]);
      rx_crc_ok = (nb % 8 == 0) && (nb >= 24) && (c == 16'hF0B8);
      rx_len = nb / 8 - 2;
      for (int k = 0; k < 64; k++) begin
        if (k < rx_len) for (int j = 0; j < 8; j++) rx_bytes[k][j] = rx_bits[8*k+j];
      end
      rx_frames++;
    end
  endtask

  always @(negedge clk) begin
    if (samp) begin
      if (tx_bit) begin
        rx_ones++;
        if (rx_ones == 7) begin
          if (rx_in_frame) rx_aborts++;
          rx_in_frame = 0;
        end
        if (rx_in_frame && rx_nbits < 2048) begin rx_bits[rx_nbits] = 1'b1; rx_nbits++; end
      end else begin
        if (rx_ones == 6) begin
          rx_flags++;
          close_frame();
          rx_in_frame = 1;
          rx_nbits = 0;
        end else if (rx_ones != 5) begin
          if (rx_in_frame && rx_nbits < 2048) begin rx_bits[rx_nbits] = 1'b0; rx_nbits++; end
        end
        rx_ones = 0;
      end
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_frame(input int prev);
    for (int t = 0; t < 20000 && rx_frames == prev; t++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int f0, a0, len, bad;
    logic [7:0] b, seed, step;
    repeat (3) @(negedge clk);
    // R6 R9: reset state
    check(tx_bit == 1'b1, "R6 reset line", tx_bit, 1);
    check(fifo_empty == 1'b1, "R9 reset empty", fifo_empty, 1);
    check(fifo_full == 1'b0, "R9 reset full", fifo_full, 0);
    check(ctrl_rdata == 8'h00, "R1 reset tags", ctrl_rdata, 0);
    rst_n = 1;
    repeat (300) @(negedge clk);
    check(rx_flags >= 3, "R6 idle flags", rx_flags, 3);
    check(rx_frames == 0 && rx_aborts == 0, "R6 idle no frame", rx_frames, 0);

    // vector table walk: R4 R5 R10
    for (int v = 0; v < NVEC; v++) begin
      len = int'(VECS[v][23:16]); seed = VECS[v][15:8]; step = VECS[v][7:0];
      f0 = rx_frames; a0 = rx_aborts;
      for (int i = 0; i < len; i++) begin
        b = seed + step * 8'(i);
        if (i == len - 1) reg_write(1'b1, 8'h01);
        reg_write(1'b0, b);
      end
      wait_frame(f0);
      check(rx_frames == f0 + 1, "R4 frame seen", rx_frames, f0 + 1);
      check(rx_crc_ok, "R4 fcs residue", rx_crc_ok, 1);
      check(rx_len == len, "R5 length after destuff", rx_len, len);
      bad = 0;
      for (int i = 0; i < len; i++) if (rx_bytes[i] != seed + step * 8'(i)) bad++;
      check(bad == 0, "R10 byte values", bad, 0);
      check(rx_aborts == a0, "R3 no stray abort", rx_aborts, a0);
    end

    // R1 R2 R3: abort tag on second byte
    f0 = rx_frames; a0 = rx_aborts;
    reg_write(1'b0, 8'h11);
    reg_write(1'b1, 8'h02);
    check(ctrl_rdata == 8'h02, "R1 tag readback", ctrl_rdata, 2);
    reg_write(1'b0, 8'h22);
    check(ctrl_rdata == 8'h00, "R1 tag self clear", ctrl_rdata, 0);
    reg_write(1'b0, 8'h33);
    reg_write(1'b1, 8'h01);
    reg_write(1'b0, 8'h44);
    wait_frame(f0);
    check(rx_aborts == a0 + 1, "R3 abort sent", rx_aborts, a0 + 1);
    check(rx_frames == f0 + 1 && rx_len == 2, "R2 next frame length", rx_len, 2);
    check(rx_bytes[0] == 8'h33 && rx_bytes[1] == 8'h44, "R2 untagged follow bytes",
          rx_bytes[0], 8'h33);
    check(rx_crc_ok, "R2 follow frame fcs", rx_crc_ok, 1);

    // R8: underrun
    f0 = rx_frames; a0 = rx_aborts;
    ur_seen = 0;
    reg_write(1'b0, 8'h5A);
    repeat (300) @(negedge clk);
    check(ur_seen == 1'b1, "R8 underrun pulse", ur_seen, 1);
    check(rx_aborts == a0 + 1, "R8 underrun abort", rx_aborts, a0 + 1);
    check(rx_frames == f0, "R8 no frame", rx_frames, f0);
    check(fifo_empty == 1'b1, "R9 empty after", fifo_empty, 1);

    // R7 R9: fill with line held, drop 17th
    ser_run = 0;
    repeat (10) @(negedge clk);
    f0 = rx_frames;
    for (int i = 0; i < 16; i++) begin
      if (i == 15) reg_write(1'b1, 8'h01);
      reg_write(1'b0, 8'hA0 + 8'(i));
      if (i == 14) check(fifo_full == 1'b0, "R9 not full at 15", fifo_full, 0);
    end
    check(fifo_full == 1'b1, "R9 full at 16", fifo_full, 1);
    check(fifo_empty == 1'b0, "R9 not empty", fifo_empty, 0);
    reg_write(1'b1, 8'h02);
    reg_write(1'b0, 8'hEE);
    check(ctrl_rdata == 8'h00, "R1 clear on dropped write", ctrl_rdata, 0);
    check(fifo_full == 1'b1, "R7 still full", fifo_full, 1);
    ser_run = 1;
    wait_frame(f0);
    check(rx_len == 16, "R7 sixteen kept", rx_len, 16);
    bad = 0;
    for (int i = 0; i < 16; i++) if (rx_bytes[i] != 8'hA0 + 8'(i)) bad++;
    check(bad == 0, "R7 stored bytes intact", bad, 0);
    a0 = rx_aborts;
    repeat (300) @(negedge clk);
    check(rx_frames == f0 + 1 && rx_aborts == a0, "R7 dropped byte not sent", rx_frames, f0 + 1);
    finish_run();
  end
endmodule